// File: doc/BRIEF.md
# Two-Wire Master Status and Interrupt Unit

This unit holds the event flags of a two-wire bus master and turns them into a single level interrupt. The bus sequencer reports events to it: a byte received, the transmit holding byte taken into the shifter, the shifter starved of data, a missing acknowledge, and a live "line idle" level. Software reaches the unit through strobes that the surrounding register decode already produces: a status read, a receive holding read, a transmit holding write, a start command, and separate set and clear writes to the interrupt mask.

Each flag follows its own clearing rule. The transfer-complete flag tracks a live level and is not a latched event. The receive-ready and transmit-ready flags change when the holding registers are accessed. The three error flags stay set until the status is read. A read never loses an error event that arrives in the same cycle. The interrupt output is the registered OR of the status ANDed with the mask.

Top module: `twi_stat_irq`

## Requirements
- R1: Status bit positions are fixed: bit 0 transfer complete, bit 1 receive ready, bit 2 transmit ready, bit 6 overrun, bit 7 underrun, bit 8 no-acknowledge. Every other status bit reads 0.
- R2: After reset, with `lineIdle` high, status reads 0x005 (complete and transmit ready), the mask reads 0 and `irq` is 0.
- R3: Transfer complete is not affected by a status read. A `startWr` or `thrWr` makes it 0 at the next edge. It then stays 0 until `lineIdle` has been low for at least one cycle. Apart from that case, each edge loads it with the current `lineIdle`.
- R4: Receive ready is set at the edge after `rxByte` and cleared at the edge after `rhrRd`. If both arrive in the same cycle, it stays set.
- R5: Overrun is set at the edge after `rxByte` arrives while receive ready is 1 and `rhrRd` is low.
- R6: Transmit ready is cleared at the edge after `thrWr` and set at the edge after `txLoad`. If both arrive in the same cycle, `thrWr` wins.
- R7: Underrun is set at the edge after `shiftNeed` arrives while transmit ready is 1 and `thrWr` is low. When `HAS_UNDERRUN` is 0, bit 7 always reads 0.
- R8: No-acknowledge is set at the edge after `nackEvt`.
- R9: Overrun, underrun and no-acknowledge hold until `statusRd`, which clears them at the next edge. A set event in the same cycle as the read leaves that flag set.
- R10: `ierWr` sets the mask bits that are 1 in `ierData`, and `idrWr` clears the mask bits that are 1 in `idrData`. When both touch the same bit in one cycle, the clear wins. Mask bits for unimplemented status positions read 0.
- R11: At each edge, `irq` is loaded with the OR of (status AND mask) as they stood before that edge. In a cycle where `ierWr` or `idrWr` is high, `irq` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ierWr | input | 1 | Mask set write strobe |
| ierData | input | STW | Bits to set in the mask |
| idrWr | input | 1 | Mask clear write strobe |
| idrData | input | STW | Bits to clear in the mask |
| statusRd | input | 1 | Status read strobe |
| rhrRd | input | 1 | Receive holding register read strobe |
| thrWr | input | 1 | Transmit holding register write strobe |
| startWr | input | 1 | Start command strobe |
| lineIdle | input | 1 | Sequencer level: holding and shifter empty, stop sent |
| rxByte | input | 1 | Sequencer pulse: byte received into holding register |
| txLoad | input | 1 | Sequencer pulse: holding byte moved to shifter |
| shiftNeed | input | 1 | Sequencer pulse: shifter wants a byte |
| nackEvt | input | 1 | Sequencer pulse: acknowledge missing |
| status | output | STW | Status flags |
| maskOut | output | STW | Current interrupt mask |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check every cycle that the flag set and clear rules respond to their strobes at the next edge. They also check that the sticky flags persist between reads, that mask writes take effect, that `irq` holds through a mask write, and that reserved bits stay 0. Some behaviour shows up only over sequences of stimulus, so only the bench scenarios can demonstrate it. One case is transfer complete staying low after a start until the idle line has dropped and come back. Others are an event racing a clearing read, a mask set and clear colliding on one bit, and `irq` tracking a long random mix of events and mask changes.

// File: rtl/twi_stat_pkg.sv
package twi_stat_pkg;
  localparam int BIT_TXC = 0;
  localparam int BIT_RXR = 1;
  localparam int BIT_TXR = 2;
  localparam int BIT_OVR = 6;
  localparam int BIT_UNR = 7;
  localparam int BIT_NAK = 8;
  localparam int MIN_W   = 9;

  typedef struct packed {
    logic setRx;
    logic clrRx;
    logic setOvr;
    logic setTx;
    logic clrTx;
    logic setUnr;
    logic setNak;
    logic clrSticky;
    logic armBusy;
    logic maskHold;
  } stat_strobe_t;
endpackage

// File: rtl/twi_stat_ctrl.sv
module twi_stat_ctrl
  import twi_stat_pkg::*;
#(
  parameter int STW          = 9,
  parameter bit HAS_UNDERRUN = 1'b1
) (
  input  logic             ierWr,
  input  logic [STW-1:0]   ierData,
  input  logic             idrWr,
  input  logic [STW-1:0]   idrData,
  input  logic             statusRd,
  input  logic             rhrRd,
  input  logic             thrWr,
  input  logic             startWr,
  input  logic             rxByte,
  input  logic             txLoad,
  input  logic             shiftNeed,
  input  logic             nackEvt,
  input  logic             rxRdyNow,
  input  logic             txRdyNow,
  output stat_strobe_t     strb,
  output logic [STW-1:0]   maskSetVec,
  output logic [STW-1:0]   maskClrVec
);
  logic unrEvent;

  generate
    if (HAS_UNDERRUN) begin : g_unr
      assign unrEvent = shiftNeed & txRdyNow & ~thrWr;
    end else begin : g_no_unr
      logic unusedUnr;
      assign unusedUnr = shiftNeed & txRdyNow;
      assign unrEvent  = 1'b0;
    end
  endgenerate

  always_comb begin
    strb.setRx     = rxByte;
    strb.clrRx     = rhrRd;
    strb.setOvr    = rxByte & rxRdyNow & ~rhrRd;
    strb.setTx     = txLoad;
    strb.clrTx     = thrWr;
    strb.setUnr    = unrEvent;
    strb.setNak    = nackEvt;
    strb.clrSticky = statusRd;
    strb.armBusy   = startWr | thrWr;
    strb.maskHold  = ierWr | idrWr;
    maskSetVec     = ierWr ? ierData : '0;
    maskClrVec     = idrWr ? idrData : '0;
  end
endmodule

// File: rtl/twi_stat_dp.sv
module twi_stat_dp
  import twi_stat_pkg::*;
#(
  parameter int STW = 9,
  parameter logic [STW-1:0] VALID_MASK = '1
) (
  input  logic           clk,
  input  logic           rstN,
  input  stat_strobe_t   strb,
  input  logic [STW-1:0] maskSetVec,
  input  logic [STW-1:0] maskClrVec,
  input  logic           lineIdle,
  output logic           rxRdyNow,
  output logic           txRdyNow,
  output logic [STW-1:0] status,
  output logic [STW-1:0] maskOut,
  output logic           irq
);
  logic txComp, busy, rxRdy, txRdy, ovr, unr, nak;
  logic busyNext;
  logic [STW-1:0] maskReg;

  assign busyNext = strb.armBusy | (busy & lineIdle);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      txComp <= 1'b1;
    end else begin
      busy   <= busyNext;
      txComp <= lineIdle & ~busyNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxRdy <= 1'b0;
      txRdy <= 1'b1;
    end else begin
      if (strb.setRx)      rxRdy <= 1'b1;
      else if (strb.clrRx) rxRdy <= 1'b0;
      if (strb.clrTx)      txRdy <= 1'b0;
      else if (strb.setTx) txRdy <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovr <= 1'b0;
      unr <= 1'b0;
      nak <= 1'b0;
    end else begin
      if (strb.setOvr)          ovr <= 1'b1;
      else if (strb.clrSticky)  ovr <= 1'b0;
      if (strb.setUnr)          unr <= 1'b1;
      else if (strb.clrSticky)  unr <= 1'b0;
      if (strb.setNak)          nak <= 1'b1;
      else if (strb.clrSticky)  nak <= 1'b0;
    end
  end

  always_comb begin
    status          = '0;
    status[BIT_TXC] = txComp;
    status[BIT_RXR] = rxRdy;
    status[BIT_TXR] = txRdy;
    status[BIT_OVR] = ovr;
    status[BIT_UNR] = unr;
    status[BIT_NAK] = nak;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      irq     <= 1'b0;
    end else begin
      maskReg <= (maskReg | maskSetVec) & ~maskClrVec & VALID_MASK;
      if (!strb.maskHold) irq <= |(status & maskReg);
    end
  end

  assign maskOut  = maskReg;
  assign rxRdyNow = rxRdy;
  assign txRdyNow = txRdy;
endmodule

// File: rtl/twi_stat_irq.sv
module twi_stat_irq
  import twi_stat_pkg::*;
#(
  parameter int STW          = 9,
  parameter bit HAS_UNDERRUN = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           ierWr,
  input  logic [STW-1:0] ierData,
  input  logic           idrWr,
  input  logic [STW-1:0] idrData,
  input  logic           statusRd,
  input  logic           rhrRd,
  input  logic           thrWr,
  input  logic           startWr,
  input  logic           lineIdle,
  input  logic           rxByte,
  input  logic           txLoad,
  input  logic           shiftNeed,
  input  logic           nackEvt,
  output logic [STW-1:0] status,
  output logic [STW-1:0] maskOut,
  output logic           irq
);
  localparam logic [STW-1:0] VALID_MASK = STW'((1 << BIT_TXC) | (1 << BIT_RXR) |
      (1 << BIT_TXR) | (1 << BIT_OVR) | (HAS_UNDERRUN ? (1 << BIT_UNR) : 0) | (1 << BIT_NAK));

  stat_strobe_t   strb;
  logic [STW-1:0] maskSetVec, maskClrVec;
  logic           rxRdyNow, txRdyNow;

  twi_stat_ctrl #(.STW(STW), .HAS_UNDERRUN(HAS_UNDERRUN)) u_ctrl (
    .ierWr(ierWr), .ierData(ierData), .idrWr(idrWr), .idrData(idrData),
    .statusRd(statusRd), .rhrRd(rhrRd), .thrWr(thrWr), .startWr(startWr),
    .rxByte(rxByte), .txLoad(txLoad), .shiftNeed(shiftNeed), .nackEvt(nackEvt),
    .rxRdyNow(rxRdyNow), .txRdyNow(txRdyNow), .strb(strb),
    .maskSetVec(maskSetVec), .maskClrVec(maskClrVec)
  );

  twi_stat_dp #(.STW(STW), .VALID_MASK(VALID_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .maskSetVec(maskSetVec),
    .maskClrVec(maskClrVec), .lineIdle(lineIdle), .rxRdyNow(rxRdyNow),
    .txRdyNow(txRdyNow), .status(status), .maskOut(maskOut), .irq(irq)
  );
endmodule

// File: rtl/twi_stat_irq_chk.sv
module twi_stat_irq_chk
  import twi_stat_pkg::*;
#(
  parameter int STW          = 9,
  parameter bit HAS_UNDERRUN = 1'b1
) (
  input logic           clk,
  input logic           rstN,
  input logic           ierWr,
  input logic [STW-1:0] ierData,
  input logic           idrWr,
  input logic [STW-1:0] idrData,
  input logic           statusRd,
  input logic           rhrRd,
  input logic           thrWr,
  input logic           startWr,
  input logic           lineIdle,
  input logic           rxByte,
  input logic           txLoad,
  input logic           shiftNeed,
  input logic           nackEvt,
  input logic [STW-1:0] status,
  input logic [STW-1:0] maskOut,
  input logic           irq
);
  localparam logic [STW-1:0] VALID_MASK = STW'((1 << BIT_TXC) | (1 << BIT_RXR) |
      (1 << BIT_TXR) | (1 << BIT_OVR) | (HAS_UNDERRUN ? (1 << BIT_UNR) : 0) | (1 << BIT_NAK));

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (status & ~VALID_MASK) == '0);

  p_txc_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (startWr | thrWr) |=> !status[BIT_TXC]);

  p_txc_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
    !lineIdle |=> !status[BIT_TXC]);

  p_rx_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rhrRd && !rxByte) |=> !status[BIT_RXR]);

  p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxByte && status[BIT_RXR] && !rhrRd) |=> status[BIT_OVR]);

  p_tx_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    thrWr |=> !status[BIT_TXR]);

  p_tx_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (txLoad && !thrWr) |=> status[BIT_TXR]);

  generate
    if (HAS_UNDERRUN) begin : g_unr
      p_unr_set_r7: assert property (@(posedge clk) disable iff (!rstN)
        (shiftNeed && status[BIT_TXR] && !thrWr) |=> status[BIT_UNR]);
    end else begin : g_no_unr
      p_unr_absent_r7: assert property (@(posedge clk) disable iff (!rstN)
        !status[BIT_UNR] || shiftNeed);
    end
  endgenerate

  p_nak_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    nackEvt |=> status[BIT_NAK]);

  p_nak_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (status[BIT_NAK] && !statusRd) |=> status[BIT_NAK]);

  p_nak_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !nackEvt) |=> !status[BIT_NAK]);

  p_mask_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ierWr && !idrWr) |=> ((maskOut & $past(ierData) & VALID_MASK) == ($past(ierData) & VALID_MASK)));

  p_mask_clr_r10: assert property (@(posedge clk) disable iff (!rstN)
    idrWr |=> ((maskOut & $past(idrData)) == '0));

  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ierWr | idrWr) |=> $stable(irq));
endmodule

bind twi_stat_irq twi_stat_irq_chk #(.STW(STW), .HAS_UNDERRUN(HAS_UNDERRUN)) u_chk (
  .clk(clk), .rstN(rstN), .ierWr(ierWr), .ierData(ierData), .idrWr(idrWr),
  .idrData(idrData), .statusRd(statusRd), .rhrRd(rhrRd), .thrWr(thrWr),
  .startWr(startWr), .lineIdle(lineIdle), .rxByte(rxByte), .txLoad(txLoad),
  .shiftNeed(shiftNeed), .nackEvt(nackEvt), .status(status), .maskOut(maskOut),
  .irq(irq)
);

// File: tb/sim_twi_stat_irq.sv
module sim_twi_stat_irq;
  localparam int STW = 9;
  localparam logic [STW-1:0] VALIDM = 9'h1C7;

  logic clk = 1'b0;
  logic rstN;
  logic ierWr, idrWr, statusRd, rhrRd, thrWr, startWr, lineIdle;
  logic rxByte, txLoad, shiftNeed, nackEvt;
  logic [STW-1:0] ierData, idrData;
  logic [STW-1:0] status, maskOut;
  logic irq;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  logic mTxc, mBusy, mRx, mTx, mOvr, mUnr, mNak, mIrq;
  logic [STW-1:0] mMask;

  always #2.5 clk = ~clk;

  twi_stat_irq #(.STW(STW), .HAS_UNDERRUN(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .ierWr(ierWr), .ierData(ierData), .idrWr(idrWr),
    .idrData(idrData), .statusRd(statusRd), .rhrRd(rhrRd), .thrWr(thrWr),
    .startWr(startWr), .lineIdle(lineIdle), .rxByte(rxByte), .txLoad(txLoad),
    .shiftNeed(shiftNeed), .nackEvt(nackEvt), .status(status), .maskOut(maskOut),
    .irq(irq)
  );

  function automatic logic [STW-1:0] expStatus();
    logic [STW-1:0] s;
    s = '0;
    s[0] = mTxc; s[1] = mRx; s[2] = mTx;
    s[6] = mOvr; s[7] = mUnr; s[8] = mNak;
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk("R1 reserved bits", 32'(status & ~VALIDM), 32'h0);
    chk("R3 transfer complete", 32'(status[0]), 32'(mTxc));
    chk("R4 receive ready", 32'(status[1]), 32'(mRx));
    chk("R5 overrun", 32'(status[6]), 32'(mOvr));
    chk("R6 transmit ready", 32'(status[2]), 32'(mTx));
    chk("R7 underrun", 32'(status[7]), 32'(mUnr));
    chk("R8 no-ack", 32'(status[8]), 32'(mNak));
    chk("R10 mask", 32'(maskOut), 32'(mMask));
    chk("R11 irq", 32'(irq), 32'(mIrq));
  endtask

  task automatic clearIns();
    ierWr = 0; idrWr = 0; statusRd = 0; rhrRd = 0; thrWr = 0; startWr = 0;
    rxByte = 0; txLoad = 0; shiftNeed = 0; nackEvt = 0; ierData = '0; idrData = '0;
  endtask

  // inputs are set; model the edge, move to the next negedge and compare
  task automatic stepTo();
    logic bN, tcN, rxN, ovN, txN, unN, nkN, iqN;
    logic [STW-1:0] mkN;
    bN  = (startWr | thrWr) | (mBusy & lineIdle);
    tcN = lineIdle & ~bN;
    rxN = rxByte ? 1'b1 : (rhrRd ? 1'b0 : mRx);
    ovN = (rxByte & mRx & ~rhrRd) ? 1'b1 : (statusRd ? 1'b0 : mOvr);
    txN = thrWr ? 1'b0 : (txLoad ? 1'b1 : mTx);
    unN = (shiftNeed & mTx & ~thrWr) ? 1'b1 : (statusRd ? 1'b0 : mUnr);
    nkN = nackEvt ? 1'b1 : (statusRd ? 1'b0 : mNak);
    mkN = (mMask | (ierWr ? ierData : '0)) & ~(idrWr ? idrData : '0) & VALIDM;
    iqN = (ierWr | idrWr) ? mIrq : |(expStatus() & mMask);
    @(negedge clk);
    mBusy = bN; mTxc = tcN; mRx = rxN; mOvr = ovN; mTx = txN;
    mUnr = unN; mNak = nkN; mMask = mkN; mIrq = iqN;
    checkAll();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL R2 watchdog expired actual 0 expected 1");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin : main
    int seedDummy;
    seedDummy = $urandom(32'd4711);
    clearIns();
    lineIdle = 1'b1;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    mTxc = 1; mBusy = 0; mRx = 0; mTx = 1; mOvr = 0; mUnr = 0; mNak = 0;
    mMask = '0; mIrq = 0;
    @(negedge clk);
    chk("R2 reset status", 32'(status), 32'h005);
    chk("R2 reset mask", 32'(maskOut), 32'h0);
    chk("R2 reset irq", 32'(irq), 32'h0);

    // R3: start drops complete; held low until the idle line dips
    startWr = 1; stepTo(); clearIns();
    chk("R3 after start", 32'(status[0]), 32'h0);
    stepTo(); stepTo();
    chk("R3 held while idle stays high", 32'(status[0]), 32'h0);
    statusRd = 1; stepTo(); clearIns();
    lineIdle = 0; stepTo();
    lineIdle = 1; stepTo();
    chk("R3 back after idle dip", 32'(status[0]), 32'h1);

    // R9: event racing a clearing read
    nackEvt = 1; stepTo();
    statusRd = 1; stepTo(); clearIns();
    chk("R9 event with read keeps flag", 32'(status[8]), 32'h1);
    statusRd = 1; stepTo(); clearIns();
    chk("R9 read clears flag", 32'(status[8]), 32'h0);

    // R4/R5: read and byte in same cycle, then overrun
    rxByte = 1; stepTo();
    rhrRd = 1; stepTo(); clearIns();
    chk("R4 byte wins over read", 32'(status[1]), 32'h1);
    chk("R5 no overrun when read", 32'(status[6]), 32'h0);
    rxByte = 1; stepTo(); clearIns();
    chk("R5 overrun set", 32'(status[6]), 32'h1);

    // R6/R7: write wins, underrun on empty holding
    thrWr = 1; txLoad = 1; stepTo(); clearIns();
    chk("R6 write beats load", 32'(status[2]), 32'h0);
    txLoad = 1; stepTo(); clearIns();
    shiftNeed = 1; stepTo(); clearIns();
    chk("R7 underrun set", 32'(status[7]), 32'h1);

    // R10/R11: clear wins, irq held during mask write
    ierWr = 1; ierData = '1; idrWr = 1; idrData = 9'h100; stepTo(); clearIns();
    chk("R10 clear wins and invalid bits dropped", 32'(maskOut), 32'(VALIDM & ~9'h100));
    chk("R11 irq held in mask write cycle", 32'(irq), 32'h0);
    stepTo();
    chk("R11 irq asserted from masked status", 32'(irq), 32'h1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      clearIns();
      ierWr = ($urandom % 12) == 0;  ierData = STW'($urandom);
      idrWr = ($urandom % 12) == 0;  idrData = STW'($urandom);
      statusRd = ($urandom % 6) == 0;
      rhrRd = ($urandom % 5) == 0;
      thrWr = ($urandom % 6) == 0;
      startWr = ($urandom % 20) == 0;
      rxByte = ($urandom % 5) == 0;
      txLoad = ($urandom % 5) == 0;
      shiftNeed = ($urandom % 9) == 0;
      nackEvt = ($urandom % 15) == 0;
      if (($urandom % 6) == 0) lineIdle = ~lineIdle;
      stepTo();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule